// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits between a CPU core and its interrupt sources. Three classes of request arrive at it: reset causes, a non-maskable group, and a range of maskable peripheral requests. Each class has its own gating rules. Every request slot is tied to a fixed word address in a 32-entry vector table at the top of the address map. A higher slot number means both higher priority and a higher address. The block picks the highest-priority qualified request and raises `irq_o`. When the CPU acknowledges, the block latches the winner's vector address, and that address holds steady while the CPU fetches the handler pointer.

The block also watches instruction fetches. A fetch that lands in the peripheral register window at the bottom of memory counts as a reset cause. It raises `reset_req_o` and claims the top vector, the same as an external reset cause.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The vector address of slot s is 0xFFC0 + 2*s, so slot 31 maps to 0xFFFE and each lower slot sits 2 bytes lower.
- R2: While any bit of `rst_src_i` is high, `reset_req_o` and `irq_o` are high and slot 31 wins, whatever the enables, the global enable and the other requests are.
- R3: A fetch (`fetch_i` high) with `fetch_addr_i` in 0x0000..0x01FF raises `reset_req_o` in the same cycle and wins slot 31. A fetch at 0x0200 or above, or an address with `fetch_i` low, has no such effect.
- R4: Slot 30 (0xFFFC) is pending when some bit has both `nmi_req_i` and `nmi_en_i` high, independent of `gie_i`. A request whose own enable bit is low has no effect.
- R5: Bit i of `mask_req_i` drives slot 14+i (slots 14..29). It is pending only when that bit, bit i of `mask_en_i` and `gie_i` are all high.
- R6: Among pending slots the highest number wins. Slot 29 (0xFFFA) beats slot 28 (0xFFF8), and slot 17 (mask bit 3) yields 0xFFE2.
- R7: Slots 0..13 (0xFFC0..0xFFDA) have no request input and never win, so a latched address is never below 0xFFDC.
- R8: `irq_o` follows the pending requests in the same cycle. `vec_addr_o` takes the winner's address at a clock edge where `ack_i` and `irq_o` are both high. At every other edge it keeps its value, including an edge where `ack_i` is high with nothing pending.
- R9: While `rst_n` is low, `vec_addr_o` is 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_src_i | input | 3 | Reset cause lines, any one claims slot 31 |
| nmi_req_i | input | 3 | Non-maskable group request lines |
| nmi_en_i | input | 3 | Individual enables for the non-maskable lines |
| mask_req_i | input | 16 | Maskable requests, bit i is slot 14+i |
| mask_en_i | input | 16 | Individual enables for maskable requests |
| gie_i | input | 1 | Global enable for maskable requests |
| fetch_i | input | 1 | An instruction fetch is taking place this cycle |
| fetch_addr_i | input | 16 | Address of the instruction fetch |
| ack_i | input | 1 | CPU acknowledge, latches the current winner |
| irq_o | output | 1 | A qualified request is pending |
| reset_req_o | output | 1 | A reset cause or an illegal fetch is present |
| vec_addr_o | output | 16 | Latched vector word address |

## Verification
A wrong gating term shows up in the same cycle as a wrong `irq_o` or `reset_req_o`. A wrong priority order or address mapping is held back until the next acknowledge, and then shows as a wrong `vec_addr_o` one edge later. A fault in the latch shows as a `vec_addr_o` that changes on an edge with no acknowledge, or that fails to load on an acknowledged one. Because the bench compares all three outputs against its model on every cycle, each of these errors appears at most one edge after the stimulus that exposes it.

// File: rtl/ivc_pkg.sv
`timescale 1ns/1ps
package ivc_pkg;
    localparam int NUM_VEC_DEF  = 32;
    localparam int LOW_USED_DEF = 14;
    localparam int RST_W_DEF    = 3;
    localparam int NMI_W_DEF    = 3;
    localparam int ADDR_W       = 16;
    localparam int SLOT_W       = $clog2(NUM_VEC_DEF);

    typedef struct packed {
        logic [ADDR_W-1:0] vec;
    } ivc_state_t;

    // word address of a slot: base plus two bytes per slot
    function automatic logic [ADDR_W-1:0] slot_addr(
        input logic [ADDR_W-1:0] base,
        input logic [SLOT_W-1:0] slot
    );
        logic [ADDR_W-1:0] off;
        off = ADDR_W'(slot) << 1;
        return base + off;
    endfunction
endpackage

// File: rtl/ivc_fetch_guard.sv
`timescale 1ns/1ps
module ivc_fetch_guard #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] PERIPH_END = 16'h0200
) (
    input  logic              fetch_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              bad_o
);
    // fetches below the end of the peripheral register window are illegal
    always_comb begin
        bad_o = fetch_i && (addr_i < PERIPH_END);
    end
endmodule

// File: rtl/ivc_gate.sv
`timescale 1ns/1ps
module ivc_gate #(
    parameter int NUM_VEC  = 32,
    parameter int LOW_USED = 14,
    parameter int NMI_W    = 3,
    localparam int RST_SLOT = NUM_VEC - 1,
    localparam int NMI_SLOT = NUM_VEC - 2,
    localparam int MASK_CNT = NUM_VEC - 2 - LOW_USED
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rst_any_i,
    input  logic [NMI_W-1:0]    nmi_req_i,
    input  logic [NMI_W-1:0]    nmi_en_i,
    input  logic [MASK_CNT-1:0] mask_req_i,
    input  logic [MASK_CNT-1:0] mask_en_i,
    input  logic                gie_i,
    output logic [NUM_VEC-1:0]  qual_o
);
    logic nmi_any;
    assign nmi_any = |(nmi_req_i & nmi_en_i);

    for (genvar s = 0; s < NUM_VEC; s++) begin : g_slot
        if (s == RST_SLOT) begin : g_rst
            assign qual_o[s] = rst_any_i;
        end else if (s == NMI_SLOT) begin : g_nmi
            assign qual_o[s] = nmi_any;
        end else if (s >= LOW_USED) begin : g_mask
            assign qual_o[s] = mask_req_i[s-LOW_USED] & mask_en_i[s-LOW_USED] & gie_i;
        end else begin : g_unused
            assign qual_o[s] = 1'b0;
        end
    end

    // R5: with the global enable low no maskable slot may qualify
    a_r5_gie_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |-> (qual_o[NMI_SLOT-1:LOW_USED] == '0));

    // R4: an enabled non-maskable line qualifies slot 30 regardless of gie_i
    a_r4_nmi_ignores_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (|(nmi_req_i & nmi_en_i)) |-> qual_o[NMI_SLOT]);
endmodule

// File: rtl/ivc_prio.sv
`timescale 1ns/1ps
module ivc_prio #(
    parameter int NUM_VEC = 32,
    localparam int SLOT_W = $clog2(NUM_VEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_VEC-1:0] qual_i,
    output logic              valid_o,
    output logic [SLOT_W-1:0] slot_o
);
    // ascending scan: the last hit, i.e. the highest slot, wins
    always_comb begin
        valid_o = 1'b0;
        slot_o  = '0;
        for (int s = 0; s < NUM_VEC; s++) begin
            if (qual_i[s]) begin
                valid_o = 1'b1;
                slot_o  = SLOT_W'(s);
            end
        end
    end

    // R6: the reported winner is itself pending
    a_r6_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> qual_i[slot_o]);

    // R6: valid exactly when something is pending
    a_r6_valid_any: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == (qual_i != '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl #(
    parameter int NUM_VEC  = ivc_pkg::NUM_VEC_DEF,
    parameter int LOW_USED = ivc_pkg::LOW_USED_DEF,
    parameter int RST_W    = ivc_pkg::RST_W_DEF,
    parameter int NMI_W    = ivc_pkg::NMI_W_DEF,
    parameter logic [15:0] VEC_BASE   = 16'hFFC0,
    parameter logic [15:0] PERIPH_END = 16'h0200,
    localparam int MASK_CNT = NUM_VEC - 2 - LOW_USED,
    localparam int SLOT_W   = $clog2(NUM_VEC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RST_W-1:0]    rst_src_i,
    input  logic [NMI_W-1:0]    nmi_req_i,
    input  logic [NMI_W-1:0]    nmi_en_i,
    input  logic [MASK_CNT-1:0] mask_req_i,
    input  logic [MASK_CNT-1:0] mask_en_i,
    input  logic                gie_i,
    input  logic                fetch_i,
    input  logic [15:0]         fetch_addr_i,
    input  logic                ack_i,
    output logic                irq_o,
    output logic                reset_req_o,
    output logic [15:0]         vec_addr_o
);
    import ivc_pkg::*;

    localparam logic [15:0] TOP_VEC  = VEC_BASE + 16'((NUM_VEC - 1) * 2);
    localparam logic [15:0] LOW_VEC  = VEC_BASE + 16'(LOW_USED * 2);

    logic               fetch_bad;
    logic               rst_any;
    logic [NUM_VEC-1:0] qual;
    logic               win_valid;
    logic [SLOT_W-1:0]  win_slot;
    logic [15:0]        win_addr;
    ivc_state_t         st_d, st_q;

    ivc_fetch_guard #(.ADDR_W(16), .PERIPH_END(PERIPH_END)) u_guard (
        .fetch_i (fetch_i),
        .addr_i  (fetch_addr_i),
        .bad_o   (fetch_bad)
    );

    assign rst_any = (|rst_src_i) | fetch_bad;

    ivc_gate #(.NUM_VEC(NUM_VEC), .LOW_USED(LOW_USED), .NMI_W(NMI_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_any_i  (rst_any),
        .nmi_req_i  (nmi_req_i),
        .nmi_en_i   (nmi_en_i),
        .mask_req_i (mask_req_i),
        .mask_en_i  (mask_en_i),
        .gie_i      (gie_i),
        .qual_o     (qual)
    );

    ivc_prio #(.NUM_VEC(NUM_VEC)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .qual_i  (qual),
        .valid_o (win_valid),
        .slot_o  (win_slot)
    );

    assign win_addr = slot_addr(VEC_BASE, win_slot);

    always_comb begin
        st_d = st_q;
        if (ack_i && win_valid) begin
            st_d.vec = win_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vec <= TOP_VEC;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o       = win_valid;
    assign reset_req_o = rst_any;
    assign vec_addr_o  = st_q.vec;

    // R2: a reset cause always claims the top slot
    a_r2_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|rst_src_i) |-> (reset_req_o && irq_o && win_slot == SLOT_W'(NUM_VEC - 1)));

    // R3: a fetch inside the peripheral window requests reset
    a_r3_fetch_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && fetch_addr_i < PERIPH_END) |-> reset_req_o);

    // R8: without acknowledge the latched address does not move
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ack_i) |-> $stable(vec_addr_o));

    // R8: acknowledge with a pending request loads the winner
    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> (vec_addr_o == $past(win_addr)));

    // R1/R7: latched address is even and never in the unused range
    a_r7_no_unused_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_addr_o[0] == 1'b0) && (vec_addr_o >= LOW_VEC));
endmodule

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rst_src = '0;
    logic [2:0]  nmi_req = '0;
    logic [2:0]  nmi_en = '0;
    logic [15:0] mreq = '0;
    logic [15:0] men = '0;
    logic        gie = 1'b0;
    logic        fetch = 1'b0;
    logic [15:0] faddr = 16'h4000;
    logic        ack = 1'b0;
    logic        irq;
    logic        rreq;
    logic [15:0] vec;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [15:0] exp_vec = 16'hFFFE;

    always #2.5 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rst_src_i(rst_src), .nmi_req_i(nmi_req),
        .nmi_en_i(nmi_en), .mask_req_i(mreq), .mask_en_i(men), .gie_i(gie),
        .fetch_i(fetch), .fetch_addr_i(faddr), .ack_i(ack),
        .irq_o(irq), .reset_req_o(rreq), .vec_addr_o(vec)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural reference: returns winning slot or -1
    function automatic int ref_slot(output bit rr);
        rr = (rst_src != 0) || (fetch && faddr < 16'h0200);
        if (rr) return 31;
        for (int b = 0; b < 3; b++) if (nmi_req[b] && nmi_en[b]) return 30;
        for (int s = 29; s >= 14; s--) if (mreq[s-14] && men[s-14] && gie) return s;
        return -1;
    endfunction

    // inputs applied at negedge, outputs checked 1 ns later, model advanced for next edge
    task automatic step(input string tag);
        bit rr;
        int w;
        #1;
        w = ref_slot(rr);
        chk(tag, "irq_o", 16'(irq), 16'(w >= 0));
        chk(tag, "reset_req_o", 16'(rreq), 16'(rr));
        chk(tag, "vec_addr_o", vec, exp_vec);
        if (ack && w >= 0) exp_vec = 16'hFFC0 + 16'(w * 2);
        @(negedge clk);
    endtask

    task automatic idle();
        rst_src = '0; nmi_req = '0; nmi_en = '0; mreq = '0; men = '0;
        gie = 0; fetch = 0; faddr = 16'h4000; ack = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R9: reset value, also with requests and ack present
        mreq = 16'hFFFF; men = 16'hFFFF; gie = 1; ack = 1;
        #1; chk("R9", "vec_addr_o in reset", vec, 16'hFFFE);
        @(negedge clk);
        idle();
        rst_n = 1;
        @(negedge clk);
        step("R9");

        // R5 R6 R1: port-2 slot 17 yields FFE2
        mreq[3] = 1; men[3] = 1; gie = 1; ack = 1; step("R6");
        ack = 0; step("R1");
        chk("R6", "slot17 address", vec, 16'hFFE2);
        // R5: global enable low blocks
        gie = 0; ack = 1; step("R5");
        // R5: individual enable low blocks
        gie = 1; men[3] = 0; step("R5");
        ack = 0; step("R5");
        // R4: nmi ignores gie
        idle(); nmi_req = 3'b010; nmi_en = 3'b010; ack = 1; step("R4");
        ack = 0; step("R4");
        chk("R4", "nmi address", vec, 16'hFFFC);
        // R4: disabled nmi line has no effect
        nmi_req = 3'b101; nmi_en = 3'b010; ack = 1; step("R4");
        ack = 0; step("R4");
        // R6: slot 29 over slot 28
        idle(); gie = 1; mreq = 16'hC000; men = 16'hC000; ack = 1; step("R6");
        ack = 0; step("R6");
        chk("R6", "slot29 address", vec, 16'hFFFA);
        // R6: slot 28 alone
        mreq = 16'h4000; ack = 1; step("R6");
        ack = 0; step("R6");
        chk("R6", "slot28 address", vec, 16'hFFF8);
        // R7: lowest used slot 14
        idle(); gie = 1; mreq = 16'h0001; men = 16'h0001; ack = 1; step("R7");
        ack = 0; step("R7");
        chk("R7", "slot14 address", vec, 16'hFFDC);
        // R2: reset cause beats everything, no enables needed
        idle(); rst_src = 3'b100; nmi_req = 3'b111; nmi_en = 3'b111; mreq = 16'hFFFF; men = 16'hFFFF; gie = 1; ack = 1; step("R2");
        ack = 0; step("R2");
        chk("R2", "reset address", vec, 16'hFFFE);
        // R3: fetch window edges
        idle(); fetch = 1; faddr = 16'h01FF; step("R3");
        faddr = 16'h0000; step("R3");
        faddr = 16'h0200; step("R3");
        fetch = 0; faddr = 16'h0010; step("R3");
        // R8: ack with nothing pending keeps value, requests without ack keep value
        gie = 1; mreq = 16'h0100; men = 16'h0100; ack = 1; step("R8");
        ack = 0; step("R8");
        chk("R8", "slot22 address", vec, 16'hFFEC);
        idle(); ack = 1; step("R8");
        ack = 0; gie = 1; mreq = 16'hFFFF; men = 16'hFFFF; step("R8");
        step("R8");
        chk("R8", "held address", vec, 16'hFFEC);
        // random traffic against the model
        for (int i = 0; i < 400; i++) begin
            rst_src = ($urandom % 16 == 0) ? 3'($urandom) : 3'b000;
            nmi_req = 3'($urandom); nmi_en = 3'($urandom);
            if ($urandom % 3 != 0) begin nmi_req = '0; end
            mreq = 16'($urandom); men = 16'($urandom); gie = 1'($urandom);
            fetch = 1'($urandom);
            faddr = ($urandom % 4 == 0) ? 16'($urandom % 1024) : 16'($urandom);
            ack = 1'($urandom);
            step("R6");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule